// File: doc/BRIEF.md
# Pin-Driven Phase Step Controller

This block runs in the reference clock domain. It turns pulses on one shared step-up pin and one shared step-down pin into signed phase-offset updates for four output channels. Each pin is first synchronised. A pulse counts only after the pin has been high for a minimum number of cycles and then low for a minimum number of cycles. Accepted steps are spaced by a minimum interval, and a pulse that arrives on both pins in the same cycle is discarded.

Each channel has its own step magnitude and three qualifying inputs: a stepping enable, a spread-spectrum-active flag and a post-divider-is-unity flag. Offsets are held in 20 ps units and saturate at ±2250 (±45 ns). A sticky flag records that saturation has happened. A new offset reaches a channel only on a cycle-boundary marker from that channel, so the delay line downstream never sees a change in the middle of a period. Before a step-down is applied, each eligible channel's synthesizer period, minus its step, is compared against a floor. If any channel would fall below the floor, the whole step is dropped: no offset changes, and a mute request is raised for a fixed number of cycles.

The main controller has four states. IDLE takes an accepted pin event (transition *accept*) to CHECK. CHECK goes to MUTE on an illegal step-down (*reject*), to APPLY when at least one channel is eligible (*commit*), and back to IDLE when no channel is eligible (*empty*). APPLY returns to IDLE once every pending channel has taken its update (*drained*). MUTE returns to IDLE when its counter expires (*expire*). Each pin qualifier has its own three states. WAIT moves to HIGH on a high sample (*rise*). HIGH moves to LOW when the pin falls after enough high samples (*arm*), or back to WAIT when it falls too early (*runt*). LOW fires the pulse and returns to WAIT once enough low samples have been seen (*fire*), or goes back to HIGH if the pin rises too early (*rearm*).

Top module: `phase_step_ctrl`

## Requirements
- R1: A pin event is produced only when, after the two-flop synchroniser, the pin has been sampled high on at least MIN_HI consecutive cycles and then low on more than MIN_LO consecutive cycles (MIN_LO+1). A shorter high run produces no step.
- R2: If events from both pins are present in the same IDLE cycle, no step is taken and no offset changes.
- R3: Two accepted steps are at least RATE_CYC cycles apart. Events that arrive earlier are dropped.
- R4: Only a channel with step_en=1, ssc_active=0 and div_is_one=1 responds to a step. The offsets of all other channels stay unchanged.
- R5: A step-up adds the channel's step_mag to its offset, and a step-down subtracts it. Offsets are two's-complement in 20 ps units, and channel i occupies phase_off[i*13 +: 13].
- R6: An offset that would pass +2250 or -2250 is set to that limit, and clip_seen goes to 1 and stays there until reset.
- R7: A channel's offset changes only in the cycle after its cyc_mark bit is high while its update is pending.
- R8: On a step-down where any eligible channel has syn_period - step_mag < period_floor, no offset changes and mute_req is high for exactly MUTE_CYC consecutive cycles.
- R9: After reset all offsets are 0, mute_req is 0 and clip_seen is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_pin | input | 1 | Shared step-up request pin (asynchronous) |
| dn_pin | input | 1 | Shared step-down request pin (asynchronous) |
| step_en | input | 4 | Per-channel stepping enable |
| ssc_active | input | 4 | Per-channel spread-spectrum-active flag |
| div_is_one | input | 4 | Per-channel post-divider-is-unity flag |
| step_mag | input | 48 | Per-channel step magnitude, 12 bits each, 20 ps units |
| syn_period | input | 48 | Per-channel synthesizer period, 12 bits each, 20 ps units |
| period_floor | input | 12 | Minimum legal period (eight VCO periods), 20 ps units |
| cyc_mark | input | 4 | Per-channel cycle-boundary marker |
| phase_off | output | 52 | Per-channel signed offset, 13 bits each |
| mute_req | output | 1 | Request to mute all outputs |
| clip_seen | output | 1 | Sticky saturation flag |

## Verification
A pin change reaches the qualifier two cycles later through the synchroniser. The pin event register rises one cycle after the last required low sample. The controller enters CHECK one cycle after that. The mute request rises one cycle after CHECK. An offset changes one cycle after the first cyc_mark seen in APPLY. The bench's reference model steps through this latency chain with plain integer counters on every rising edge. It compares each offset, mute_req and clip_seen on every falling edge, so every result is checked in exactly the cycle it is due. Each scenario is followed by a settle window longer than the rate interval, and by named checks against hand-computed offset values.

// File: rtl/phstep_pkg.sv
package phstep_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_APPLY, ST_MUTE} step_st_e;
    typedef enum logic [1:0] {PQ_WAIT, PQ_HIGH, PQ_LOW} pinq_st_e;
endpackage

// File: rtl/phstep_pin_qual.sv
module phstep_pin_qual
    import phstep_pkg::*;
#(
    parameter int MIN_HI = 13,
    parameter int MIN_LO = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic pulse
);
    localparam int MAXT = (MIN_HI > MIN_LO) ? MIN_HI : MIN_LO;
    localparam int CW   = $clog2(MAXT + 2);
    localparam logic [CW-1:0] CMAX = '1;

    logic     sync1, sync2;
    pinq_st_e qst;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
        end else begin
            sync1 <= pin;
            sync2 <= sync1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qst   <= PQ_WAIT;
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= 1'b0;
            unique case (qst)
                PQ_WAIT: if (sync2) begin
                    qst <= PQ_HIGH;
                    cnt <= CW'(1);
                end
                PQ_HIGH: begin
                    if (sync2) begin
                        if (cnt != CMAX) cnt <= cnt + 1'b1;
                    end else if (cnt >= CW'(MIN_HI)) begin
                        qst <= PQ_LOW;
                        cnt <= CW'(1);
                    end else begin
                        qst <= PQ_WAIT;
                    end
                end
                PQ_LOW: begin
                    if (sync2) begin
                        qst <= PQ_HIGH;
                        cnt <= CW'(1);
                    end else if (cnt >= CW'(MIN_LO)) begin
                        pulse <= 1'b1;
                        qst   <= PQ_WAIT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: qst <= PQ_WAIT;
            endcase
        end
    end

    // R1
    pulse_after_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> !$past(sync2));
    // R1
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

// File: rtl/phstep_lane.sv
module phstep_lane #(
    parameter int OW    = 13,
    parameter int MW    = 12,
    parameter int PW    = 12,
    parameter int LIMIT = 2250
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          commit,
    input  logic          apply,
    input  logic          dir_dn,
    input  logic          elig,
    input  logic          mark,
    input  logic [MW-1:0] mag,
    input  logic [PW-1:0] period,
    input  logic [PW-1:0] floor_p,
    output logic [OW-1:0] off,
    output logic          pend,
    output logic          short_o,
    output logic          clip_o
);
    localparam int SW = ((OW > MW) ? OW : MW) + 2;
    localparam int CW = ((PW > MW) ? PW : MW) + 1;
    localparam logic signed [SW-1:0] LIM_P = SW'(LIMIT);
    localparam logic signed [SW-1:0] LIM_N = -LIM_P;

    logic signed [SW-1:0] cur, delta, sum;
    logic [OW-1:0] tgt, tgt_c;
    logic          clip_hi, clip_lo;

    always_comb begin
        cur     = SW'($signed(off));
        delta   = $signed(SW'(mag));
        sum     = dir_dn ? (cur - delta) : (cur + delta);
        clip_hi = sum > LIM_P;
        clip_lo = sum < LIM_N;
        if (clip_hi)      tgt_c = LIM_P[OW-1:0];
        else if (clip_lo) tgt_c = LIM_N[OW-1:0];
        else              tgt_c = sum[OW-1:0];
        clip_o  = clip_hi | clip_lo;
        short_o = CW'(period) < (CW'(floor_p) + CW'(mag));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off  <= '0;
            tgt  <= '0;
            pend <= 1'b0;
        end else if (commit) begin
            tgt  <= tgt_c;
            pend <= elig;
        end else if (apply && pend && mark) begin
            off  <= tgt;
            pend <= 1'b0;
        end
    end

    // R6
    off_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(off) <= $signed(OW'(LIMIT))) && ($signed(off) >= -$signed(OW'(LIMIT))));
    // R7
    off_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (off != $past(off)) |-> $past(mark && apply));
endmodule

// File: rtl/phase_step_ctrl.sv
module phase_step_ctrl
    import phstep_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int OW       = 13,
    parameter int MW       = 12,
    parameter int PW       = 12,
    parameter int LIMIT    = 2250,
    parameter int MIN_HI   = 13,
    parameter int MIN_LO   = 13,
    parameter int RATE_CYC = 84,
    parameter int MUTE_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_pin,
    input  logic              dn_pin,
    input  logic [NCH-1:0]    step_en,
    input  logic [NCH-1:0]    ssc_active,
    input  logic [NCH-1:0]    div_is_one,
    input  logic [NCH*MW-1:0] step_mag,
    input  logic [NCH*PW-1:0] syn_period,
    input  logic [PW-1:0]     period_floor,
    input  logic [NCH-1:0]    cyc_mark,
    output logic [NCH*OW-1:0] phase_off,
    output logic              mute_req,
    output logic              clip_seen
);
    localparam int RW  = $clog2(RATE_CYC + 1);
    localparam int MCW = $clog2(MUTE_CYC + 1);

    logic           up_p, dn_p;
    step_st_e       st, st_nx;
    logic [RW-1:0]  rate_cnt;
    logic [MCW-1:0] mute_cnt;
    logic           dir_dn;
    logic [NCH-1:0] elig, pend, short_v, clip_v;
    logic           accept, reject, commit, apply;

    phstep_pin_qual #(.MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_up_q (
        .clk(clk), .rst_n(rst_n), .pin(up_pin), .pulse(up_p));
    phstep_pin_qual #(.MIN_HI(MIN_HI), .MIN_LO(MIN_LO)) u_dn_q (
        .clk(clk), .rst_n(rst_n), .pin(dn_pin), .pulse(dn_p));

    assign elig   = step_en & ~ssc_active & div_is_one;
    assign accept = (st == ST_IDLE) && (rate_cnt == '0) && (up_p ^ dn_p);
    assign reject = dir_dn && |(elig & short_v);
    assign commit = (st == ST_CHECK) && !reject;
    assign apply  = (st == ST_APPLY);

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_lane
            phstep_lane #(.OW(OW), .MW(MW), .PW(PW), .LIMIT(LIMIT)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .commit  (commit),
                .apply   (apply),
                .dir_dn  (dir_dn),
                .elig    (elig[i]),
                .mark    (cyc_mark[i]),
                .mag     (step_mag[i*MW +: MW]),
                .period  (syn_period[i*PW +: PW]),
                .floor_p (period_floor),
                .off     (phase_off[i*OW +: OW]),
                .pend    (pend[i]),
                .short_o (short_v[i]),
                .clip_o  (clip_v[i])
            );
        end
    endgenerate

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (accept) st_nx = ST_CHECK;
            ST_CHECK: begin
                if (reject)            st_nx = ST_MUTE;
                else if (elig != '0)   st_nx = ST_APPLY;
                else                   st_nx = ST_IDLE;
            end
            ST_APPLY: if ((pend & ~cyc_mark) == '0) st_nx = ST_IDLE;
            ST_MUTE:  if (mute_cnt == '0) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_cnt  <= '0;
            mute_cnt  <= '0;
            dir_dn    <= 1'b0;
            clip_seen <= 1'b0;
        end else begin
            if (accept) begin
                rate_cnt <= RW'(RATE_CYC - 1);
                dir_dn   <= dn_p;
            end else if (rate_cnt != '0) begin
                rate_cnt <= rate_cnt - 1'b1;
            end
            if ((st == ST_CHECK) && reject)          mute_cnt <= MCW'(MUTE_CYC - 1);
            else if ((st == ST_MUTE) && (mute_cnt != '0)) mute_cnt <= mute_cnt - 1'b1;
            if (commit && |(elig & clip_v)) clip_seen <= 1'b1;
        end
    end

    always_comb mute_req = (st == ST_MUTE);

    logic [RW-1:0] since_chk;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   since_chk <= RW'(RATE_CYC);
        else if (st == ST_CHECK)      since_chk <= RW'(1);
        else if (since_chk != RW'(RATE_CYC)) since_chk <= since_chk + 1'b1;
    end

    // R3
    step_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CHECK) |-> (since_chk >= RW'(RATE_CYC)));
    // R2
    both_pins_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_p && dn_p && st == ST_IDLE) |=> (st != ST_CHECK));
    // R8
    mute_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req |=> $stable(phase_off));
    // R8
    mute_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mute_req) |-> ($past(st) == ST_CHECK) && $past(dir_dn));
endmodule

// File: tb/phase_step_ctrl_bench.sv
module phase_step_ctrl_bench;
    localparam int NCH = 4, OW = 13, MW = 12, PW = 12;
    localparam int MIN_HI = 13, MIN_LO = 13, RATE = 84, MUTE = 10;

    logic clk = 0, rst_n = 0, up_pin = 0, dn_pin = 0;
    logic [NCH-1:0] step_en = '1, ssc_active = '0, div_is_one = '1, cyc_mark = '0;
    logic [NCH*MW-1:0] step_mag;
    logic [NCH*PW-1:0] syn_period;
    logic [PW-1:0] period_floor = 12'd100;
    logic [NCH*OW-1:0] phase_off;
    logic mute_req, clip_seen;

    int b_mag[NCH] = '{100, 250, 7, 1000};
    int b_per[NCH] = '{500, 500, 500, 500};
    logic [NCH-1:0] mark_mask = '1;

    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            step_mag[k*MW +: MW]   = MW'(b_mag[k]);
            syn_period[k*PW +: PW] = PW'(b_per[k]);
        end
    end

    phase_step_ctrl u_phase_step_ctrl (
        .clk(clk), .rst_n(rst_n), .up_pin(up_pin), .dn_pin(dn_pin),
        .step_en(step_en), .ssc_active(ssc_active), .div_is_one(div_is_one),
        .step_mag(step_mag), .syn_period(syn_period), .period_floor(period_floor),
        .cyc_mark(cyc_mark), .phase_off(phase_off), .mute_req(mute_req),
        .clip_seen(clip_seen));

    always #4 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0, mute_seen = 0;
    bit done = 0;
    string cur_req = "R9";

    // cycle markers: channel k every k+3 cycles
    always @(negedge clk) begin
        for (int k = 0; k < NCH; k++)
            cyc_mark[k] <= mark_mask[k] && ((cyc % (k + 3)) == 0);
    end

    // behavioural reference model
    int m_st, m_rate, m_mc, m_off[NCH], m_tgt[NCH], m_q[2], m_c[2];
    bit m_dir, m_clip, m_pd[NCH], m_pl[2], m_s1[2], m_s2[2];
    bit t_acc, t_bad, t_any, t_el[NCH], t_pin[2];
    int t_s;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_st = 0; m_rate = 0; m_mc = 0; m_dir = 0; m_clip = 0;
            for (int k = 0; k < NCH; k++) begin m_off[k] = 0; m_tgt[k] = 0; m_pd[k] = 0; end
            for (int p = 0; p < 2; p++) begin m_q[p] = 0; m_c[p] = 0; m_pl[p] = 0; m_s1[p] = 0; m_s2[p] = 0; end
        end else begin
            t_acc = (m_st == 0) && (m_rate == 0) && (m_pl[0] != m_pl[1]);
            if (t_acc) m_rate = RATE - 1;
            else if (m_rate != 0) m_rate--;
            case (m_st)
                0: if (t_acc) begin m_dir = m_pl[1]; m_st = 1; end
                1: begin
                    t_bad = 0; t_any = 0;
                    for (int k = 0; k < NCH; k++) begin
                        t_el[k] = step_en[k] && !ssc_active[k] && div_is_one[k];
                        if (t_el[k] && m_dir && (b_per[k] - b_mag[k] < int'(period_floor))) t_bad = 1;
                    end
                    if (t_bad) begin m_st = 3; m_mc = MUTE - 1; end
                    else begin
                        for (int k = 0; k < NCH; k++) begin
                            m_pd[k] = t_el[k];
                            if (t_el[k]) begin
                                t_s = m_dir ? m_off[k] - b_mag[k] : m_off[k] + b_mag[k];
                                if (t_s > 2250) begin t_s = 2250; m_clip = 1; end
                                if (t_s < -2250) begin t_s = -2250; m_clip = 1; end
                                m_tgt[k] = t_s; t_any = 1;
                            end
                        end
                        m_st = t_any ? 2 : 0;
                    end
                end
                2: begin
                    t_any = 0;
                    for (int k = 0; k < NCH; k++) begin
                        if (m_pd[k] && cyc_mark[k]) begin m_off[k] = m_tgt[k]; m_pd[k] = 0; end
                        if (m_pd[k]) t_any = 1;
                    end
                    if (!t_any) m_st = 0;
                end
                3: if (m_mc == 0) m_st = 0; else m_mc--;
                default: m_st = 0;
            endcase
            t_pin[0] = up_pin; t_pin[1] = dn_pin;
            for (int p = 0; p < 2; p++) begin
                m_pl[p] = 0;
                case (m_q[p])
                    0: if (m_s2[p]) begin m_q[p] = 1; m_c[p] = 1; end
                    1: if (m_s2[p]) m_c[p]++;
                       else if (m_c[p] >= MIN_HI) begin m_q[p] = 2; m_c[p] = 1; end
                       else m_q[p] = 0;
                    default: if (m_s2[p]) begin m_q[p] = 1; m_c[p] = 1; end
                       else if (m_c[p] >= MIN_LO) begin m_pl[p] = 1; m_q[p] = 0; end
                       else m_c[p]++;
                endcase
                m_s2[p] = m_s1[p]; m_s1[p] = t_pin[p];
            end
        end
    end

    function automatic int off_of(int k);
        return int'($signed(phase_off[k*OW +: OW]));
    endfunction

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (mute_req) mute_seen++;
            for (int k = 0; k < NCH; k++)
                if (off_of(k) != m_off[k]) begin
                    errors++;
                    $display("FAIL %s ch%0d offset actual=%0d expected=%0d", cur_req, k, off_of(k), m_off[k]);
                end
            if (mute_req != (m_st == 3)) begin
                errors++;
                $display("FAIL %s mute_req actual=%0d expected=%0d", cur_req, mute_req, (m_st == 3));
            end
            if (clip_seen != m_clip) begin
                errors++;
                $display("FAIL %s clip_seen actual=%0d expected=%0d", cur_req, clip_seen, m_clip);
            end
        end
    end

    task automatic chk(string rq, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic pulse(bit u, bit d, int hi, int lo);
        @(negedge clk); up_pin = u; dn_pin = d;
        repeat (hi) @(negedge clk);
        up_pin = 0; dn_pin = 0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic settle();
        repeat (150) @(negedge clk);
    endtask

    task automatic chk_all(string rq, int a, int b, int c, int d);
        chk(rq, off_of(0), a); chk(rq, off_of(1), b);
        chk(rq, off_of(2), c); chk(rq, off_of(3), d);
    endtask

    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R9";
        chk_all("R9", 0, 0, 0, 0);
        chk("R9 mute", mute_req, 0);
        chk("R9 clip", clip_seen, 0);

        cur_req = "R5";
        pulse(1, 0, 16, 16); settle();
        chk_all("R5 up", 100, 250, 7, 1000);

        cur_req = "R1";
        pulse(1, 0, 5, 16); settle();
        chk_all("R1 short high", 100, 250, 7, 1000);

        cur_req = "R4";
        step_en[3] = 0; ssc_active[1] = 1; div_is_one[2] = 0;
        pulse(0, 1, 16, 16); settle();
        chk_all("R4 masked", 0, 250, 7, 1000);
        step_en = '1; ssc_active = '0; div_is_one = '1;

        cur_req = "R2";
        pulse(1, 1, 16, 16); settle();
        chk_all("R2 both", 0, 250, 7, 1000);

        cur_req = "R3";
        pulse(1, 0, 16, 16); pulse(1, 0, 16, 16); settle();
        chk_all("R3 rate", 100, 500, 14, 2000);

        cur_req = "R6";
        repeat (3) begin pulse(1, 0, 16, 16); settle(); end
        chk_all("R6 sat", 400, 1250, 35, 2250);
        chk("R6 clip", clip_seen, 1);

        cur_req = "R8";
        b_per[0] = 150; mute_seen = 0;
        pulse(0, 1, 16, 16); settle();
        chk_all("R8 rollback", 400, 1250, 35, 2250);
        chk("R8 mute len", mute_seen, MUTE);
        b_per[0] = 500;

        cur_req = "R7";
        mark_mask[2] = 0;
        pulse(1, 0, 16, 16); settle();
        chk_all("R7 held", 500, 1500, 35, 2250);
        mark_mask = '1;
        settle();
        chk("R7 released", off_of(2), 42);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule